// File: doc/BRIEF.md
# Word-to-Byte Register Bus Adapter

This block lets a host that only ever reads and writes 16-bit registers talk to a peripheral register bus. That bus can run one 16-bit lane or a single 8-bit lane. Register offsets are byte offsets. A 16-bit register therefore takes two byte addresses on a narrow bus, and the offset arrives unchanged on a wide bus.

In wide mode one request becomes one strobe burst at the offset. In narrow mode one request becomes two back-to-back byte bursts: the first at the offset, then one at the offset plus one. For reads, the two halves are joined into one word. The parameter `HOST_BIG_ENDIAN` fixes which half of the word goes to which byte address.

The bus width is chosen at run time. The adapter watches for a completed write to offset 0 and takes bit 0 of that value as the new width. It powers up in narrow mode.

Top module: `regbus_width_adapter`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, `bus_strobe` is 0 and `mode_wide` is 0 (8-bit lane).
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the request completes. `rsp_done` is a single-cycle pulse, and `req_ready` returns to 1 in the following cycle.
- R3: In 16-bit mode (`bus_wide`=1), a request makes one strobe burst of `STROBE_CYCLES` cycles at `bus_addr` = offset, carrying the full word on `bus_wdata`/`bus_rdata`. `rsp_done` rises `STROBE_CYCLES` edges after the accepting edge.
- R4: In 8-bit mode, a request makes two consecutive strobe bursts of `STROBE_CYCLES` cycles each: the first at the offset, the second at offset+1 (modulo 2^`ADDR_W`). The byte travels on bits 7:0, and bits 15:8 of `bus_rdata` are ignored. `rsp_done` rises 2×`STROBE_CYCLES` edges after the accepting edge.
- R5: With `HOST_BIG_ENDIAN`=0, in 8-bit mode, word bits 15:8 go to the offset and bits 7:0 go to offset+1, for both writes and reads.
- R6: With `HOST_BIG_ENDIAN`=1, in 8-bit mode, word bits 7:0 go to the offset and bits 15:8 go to offset+1, for both writes and reads.
- R7: When a write to offset 0 completes, `mode_wide` takes bit 0 of the written value (0 = 8-bit, 1 = 16-bit). That write itself still uses the old width. Writes to other offsets leave the mode unchanged.
- R8: `rsp_rdata` is registered. It is loaded in the `rsp_done` cycle of a read and then holds its value through idle cycles and through later write requests.
- R9: `bus_we` is 1 only during strobe cycles of a write request, and is never 1 during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Adapter idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the 16-bit register |
| req_wdata | input | 16 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read word, held |
| bus_strobe | output | 1 | Peripheral bus strobe |
| bus_we | output | 1 | Peripheral bus write enable |
| bus_wide | output | 1 | 1 = 16-bit bus cycle, 0 = byte cycle |
| bus_addr | output | ADDR_W | Peripheral bus byte address |
| bus_wdata | output | 16 | Bus write data (byte cycles use bits 7:0) |
| bus_rdata | input | 16 | Bus read data (byte cycles use bits 7:0) |
| mode_wide | output | 1 | Current bus width selection |

## Verification
After the accepting edge, `rsp_done` is due `STROBE_CYCLES` edges later in wide mode and 2×`STROBE_CYCLES` edges later in narrow mode. The new `mode_wide` value and the read word are visible in that same done cycle. The bench drives and samples on falling edges. It counts falling edges from the accepting edge until done and expects exactly `STROBE_CYCLES`+1 or 2×`STROBE_CYCLES`+1. Only then does it compare the bus-side memories, the logged order and length of the bursts, and the returned word. The hold of `rsp_rdata` is checked over idle cycles and across a later write.

// File: rtl/rwa_pkg.sv
package rwa_pkg;
  typedef enum logic [1:0] {
    RWA_IDLE   = 2'd0,
    RWA_STROBE = 2'd1,
    RWA_DONE   = 2'd2
  } rwa_state_e;
endpackage

// File: rtl/rwa_strobe_timer.sv
// Counts the cycles of one strobe slot; last is high in the final cycle.
module rwa_strobe_timer #(
  parameter int unsigned CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign last = run && (cnt_q == CW'(CYCLES - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rwa_lane_steer.sv
// Chooses which half of the word belongs to the current byte slot.
module rwa_lane_steer #(
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic        phase,
  input  logic [15:0] word,
  output logic        take_hi,
  output logic [7:0]  wr_byte
);
  generate
    if (HOST_BIG_ENDIAN) begin : g_big
      assign take_hi = phase;
    end else begin : g_little
      assign take_hi = ~phase;
    end
  endgenerate

  assign wr_byte = take_hi ? word[15:8] : word[7:0];
endmodule

// File: rtl/regbus_width_adapter.sv
module regbus_width_adapter
  import rwa_pkg::*;
#(
  parameter int unsigned ADDR_W          = 8,
  parameter int unsigned STROBE_CYCLES   = 2,
  parameter bit          HOST_BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic              bus_strobe,
  output logic              bus_we,
  output logic              bus_wide,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  output logic              mode_wide
);
  localparam logic [ADDR_W-1:0] MODE_REG_OFS = '0;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rwa_state_e        state_q, state_d;
  logic              phase_q, phase_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic              mode16_q;
  logic [15:0]       asm_q, asm_d;
  logic [15:0]       rdata_q;

  logic accept, strobe_on, slot_end, final_slot, finish;
  logic take_hi;
  logic [7:0] wr_byte;

  assign accept     = req_valid && (state_q == RWA_IDLE);
  assign strobe_on  = (state_q == RWA_STROBE);
  assign final_slot = mode16_q || phase_q;
  assign finish     = slot_end && final_slot;

  rwa_strobe_timer #(.CYCLES(STROBE_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .run  (strobe_on),
    .last (slot_end)
  );

  rwa_lane_steer #(.HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) u_steer (
    .phase  (phase_q),
    .word   (wdata_q),
    .take_hi(take_hi),
    .wr_byte(wr_byte)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    unique case (state_q)
      RWA_IDLE: begin
        if (accept) begin
          state_d = RWA_STROBE;
          phase_d = 1'b0;
        end
      end
      RWA_STROBE: begin
        if (slot_end) begin
          if (final_slot) state_d = RWA_DONE;
          else            phase_d = 1'b1;
        end
      end
      RWA_DONE: state_d = RWA_IDLE;
      default:  state_d = RWA_IDLE;
    endcase
  end

  // read assembly
  always_comb begin
    if (mode16_q)     asm_d = bus_rdata;
    else if (take_hi) asm_d = {bus_rdata[7:0], asm_q[7:0]};
    else              asm_d = {asm_q[15:8], bus_rdata[7:0]};
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= RWA_IDLE;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)   asm_q <= '0;
    else if (slot_end) asm_q <= asm_d;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)           rdata_q <= '0;
    else if (finish && !wr_q)  rdata_q <= asm_d;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)                                   mode16_q <= 1'b0;
    else if (finish && wr_q && addr_q == MODE_REG_OFS) mode16_q <= wdata_q[0];
  end

  assign req_ready  = (state_q == RWA_IDLE);
  assign rsp_done   = (state_q == RWA_DONE);
  assign rsp_rdata  = rdata_q;
  assign bus_strobe = strobe_on;
  assign bus_we     = strobe_on && wr_q;
  assign bus_wide   = mode16_q;
  assign bus_addr   = addr_q + ADDR_W'(phase_q);
  assign bus_wdata  = mode16_q ? wdata_q : {8'h00, wr_byte};
  assign mode_wide  = mode16_q;
endmodule

// File: rtl/rwa_checker.sv
module rwa_checker #(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned STROBE_CYCLES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [15:0]       rsp_rdata,
  input logic              bus_strobe,
  input logic              bus_we,
  input logic              bus_wide,
  input logic [ADDR_W-1:0] bus_addr
);
  logic              prev_strb_q;
  logic [ADDR_W-1:0] prev_addr_q;
  int unsigned       seg_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_strb_q <= 1'b0;
      prev_addr_q <= '0;
      seg_len_q   <= 0;
    end else begin
      prev_strb_q <= bus_strobe;
      prev_addr_q <= bus_addr;
      if (!bus_strobe)                                   seg_len_q <= 0;
      else if (prev_strb_q && bus_addr == prev_addr_q)   seg_len_q <= seg_len_q + 1;
      else                                               seg_len_q <= 1;
    end
  end

  // R2: idle means no bus activity and no completion
  p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_strobe && !rsp_done));

  // R2: done lasts one cycle and is followed by ready
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  // R9: write enable only inside a strobe
  p_we_in_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_strobe);

  // R4: an address change inside a run is a narrow step to the next byte
  p_byte_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && prev_strb_q && bus_addr != prev_addr_q) |->
      (!bus_wide && bus_addr == ADDR_W'(prev_addr_q + 1'b1)));

  // R3: every strobe slot lasts exactly STROBE_CYCLES cycles
  p_slot_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_strb_q && (!bus_strobe || bus_addr != prev_addr_q)) |->
      (seg_len_q == STROBE_CYCLES));

  // R8: read word holds while idle with no request and after done
  p_rdata_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(rsp_rdata));

  p_rdata_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> $stable(rsp_rdata));
endmodule

bind regbus_width_adapter rwa_checker #(
  .ADDR_W       (ADDR_W),
  .STROBE_CYCLES(STROBE_CYCLES)
) u_rwa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_rdata (rsp_rdata),
  .bus_strobe(bus_strobe),
  .bus_we    (bus_we),
  .bus_wide  (bus_wide),
  .bus_addr  (bus_addr)
);

// File: tb/regbus_width_adapter_bench.sv
module rwa_bus_model #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              clr_log,
  input  logic              strobe,
  input  logic              we,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  logic [7:0]        bmem [0:(1<<ADDR_W)-1];
  logic [15:0]       wmem [0:(1<<ADDR_W)-1];
  logic [ADDR_W-1:0] log_a [0:3];
  int                log_len [0:3];
  int                log_n = 0;
  int                wcount = 0;
  logic              prev_s = 1'b0;
  logic [ADDR_W-1:0] prev_a = '0;

  assign rdata = wide ? wmem[addr] : {8'hEE, bmem[addr]};

  always @(posedge clk) begin
    prev_s <= strobe;
    prev_a <= addr;
    if (clr_log) log_n <= 0;
    else if (strobe) begin
      if (!prev_s || addr != prev_a) begin
        if (log_n < 4) begin
          log_a[log_n]   <= addr;
          log_len[log_n] <= 1;
        end
        log_n <= log_n + 1;
      end else if (log_n >= 1 && log_n <= 4) begin
        log_len[log_n-1] <= log_len[log_n-1] + 1;
      end
    end
    if (strobe && we) begin
      wcount <= wcount + 1;
      if (wide) wmem[addr] <= wdata;
      else      bmem[addr] <= wdata[7:0];
    end
  end
endmodule

module regbus_width_adapter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          clr_log = 1'b0;

  logic          le_ready, le_done, le_strobe, le_we, le_wide, le_mode;
  logic [15:0]   le_rdata, le_bwdata, le_brdata;
  logic [AW-1:0] le_baddr;
  logic          be_ready, be_done, be_strobe, be_we, be_wide, be_mode;
  logic [15:0]   be_rdata, be_bwdata, be_brdata;
  logic [AW-1:0] be_baddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbus_width_adapter #(.ADDR_W(AW), .STROBE_CYCLES(NS), .HOST_BIG_ENDIAN(1'b0)) u_regbus_width_adapter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(le_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(le_done), .rsp_rdata(le_rdata), .bus_strobe(le_strobe), .bus_we(le_we),
    .bus_wide(le_wide), .bus_addr(le_baddr), .bus_wdata(le_bwdata), .bus_rdata(le_brdata),
    .mode_wide(le_mode));

  regbus_width_adapter #(.ADDR_W(AW), .STROBE_CYCLES(NS), .HOST_BIG_ENDIAN(1'b1)) u_regbus_width_adapter_be (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(be_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(be_done), .rsp_rdata(be_rdata), .bus_strobe(be_strobe), .bus_we(be_we),
    .bus_wide(be_wide), .bus_addr(be_baddr), .bus_wdata(be_bwdata), .bus_rdata(be_brdata),
    .mode_wide(be_mode));

  rwa_bus_model #(.ADDR_W(AW)) u_le_bus (
    .clk(clk), .clr_log(clr_log), .strobe(le_strobe), .we(le_we), .wide(le_wide),
    .addr(le_baddr), .wdata(le_bwdata), .rdata(le_brdata));

  rwa_bus_model #(.ADDR_W(AW)) u_be_bus (
    .clk(clk), .clr_log(clr_log), .strobe(be_strobe), .we(be_we), .wide(be_wide),
    .addr(be_baddr), .wdata(be_bwdata), .rdata(be_brdata));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // issue one request; returns falling edges from accept to done
  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                        output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; clr_log = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; clr_log = 1'b0;
    lat = 1;
    while (!le_done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk(be_done == le_done && le_done, "R2", "done alignment", {30'd0, be_done, le_done}, 32'h3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    int lat;
    logic [15:0] d, held;
    logic [AW-1:0] off, nxt;
    int wc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(le_ready && be_ready, "R1", "ready after reset", {31'd0, le_ready}, 1);
    chk(!le_done && !be_done, "R1", "done after reset", {31'd0, le_done}, 0);
    chk(!le_strobe && !be_strobe, "R1", "strobe after reset", {31'd0, le_strobe}, 0);
    chk(!le_mode && !be_mode, "R1", "mode after reset", {31'd0, le_mode}, 0);

    // R4 R5 R6: narrow sweep including address wrap
    for (int i = 1; i <= 16; i++) begin
      off = (i == 16) ? AW'(255) : AW'(i * 3);
      nxt = off + 1'b1;
      d   = 16'((i * 16'h1357) ^ 16'hA5C3);
      do_req(1'b1, off, d, lat);
      chk(lat == 2*NS + 1, "R4", "narrow write latency", lat, 2*NS + 1);
      chk(u_le_bus.log_n == 2, "R4", "two byte slots", u_le_bus.log_n, 2);
      chk(u_le_bus.log_a[0] == off && u_le_bus.log_a[1] == nxt, "R4", "ascending byte order",
          {u_le_bus.log_a[0], u_le_bus.log_a[1]}, {off, nxt});
      chk(u_le_bus.log_len[0] == NS && u_le_bus.log_len[1] == NS, "R4", "byte slot length",
          u_le_bus.log_len[0], NS);
      chk(u_le_bus.bmem[off] == d[15:8] && u_le_bus.bmem[nxt] == d[7:0], "R5",
          "little-endian write bytes", {u_le_bus.bmem[off], u_le_bus.bmem[nxt]}, d);
      chk(u_be_bus.bmem[off] == d[7:0] && u_be_bus.bmem[nxt] == d[15:8], "R6",
          "big-endian write bytes", {u_be_bus.bmem[nxt], u_be_bus.bmem[off]}, d);
      chk(!le_mode, "R7", "mode kept by non-zero offset", {31'd0, le_mode}, 0);
      wc = u_le_bus.wcount;
      do_req(1'b0, off, 16'h0000, lat);
      chk(lat == 2*NS + 1, "R4", "narrow read latency", lat, 2*NS + 1);
      chk(le_rdata == d, "R5", "little-endian read word", le_rdata, d);
      chk(be_rdata == d, "R6", "big-endian read word", be_rdata, d);
      chk(u_le_bus.wcount == wc, "R9", "no bus write during read", u_le_bus.wcount, wc);
    end

    // R8: read word held while idle and across a write
    held = le_rdata;
    repeat (3) @(negedge clk);
    chk(le_rdata == held, "R8", "read word held while idle", le_rdata, held);
    do_req(1'b1, 8'h40, 16'h1234, lat);
    chk(le_rdata == held && be_rdata == held, "R8", "read word held across write", le_rdata, held);

    // R7: offset 0 with bit0 clear keeps narrow; bit0 set switches after that write
    do_req(1'b1, 8'h00, 16'h0002, lat);
    chk(!le_mode && !be_mode, "R7", "bit0 clear keeps narrow", {31'd0, le_mode}, 0);
    do_req(1'b1, 8'h00, 16'h8001, lat);
    chk(lat == 2*NS + 1, "R7", "mode write uses old width", lat, 2*NS + 1);
    chk(u_le_bus.bmem[0] == 8'h80 && u_le_bus.bmem[1] == 8'h01, "R7", "mode write as bytes",
        {u_le_bus.bmem[0], u_le_bus.bmem[1]}, 16'h8001);
    chk(le_mode && be_mode, "R7", "wide mode in done cycle", {31'd0, le_mode}, 1);

    // R3: wide sweep
    for (int i = 1; i <= 16; i++) begin
      off = (i == 16) ? AW'(255) : AW'(i * 2 + 1);
      d   = 16'((i * 16'h2B1D) ^ 16'h5A3C);
      do_req(1'b1, off, d, lat);
      chk(lat == NS + 1, "R3", "wide write latency", lat, NS + 1);
      chk(u_le_bus.log_n == 1 && u_le_bus.log_a[0] == off, "R3", "single wide slot",
          {u_le_bus.log_n[23:0], u_le_bus.log_a[0]}, {24'd1, off});
      chk(u_le_bus.log_len[0] == NS, "R3", "wide slot length", u_le_bus.log_len[0], NS);
      chk(u_le_bus.wmem[off] == d && u_be_bus.wmem[off] == d, "R3", "wide write word",
          u_le_bus.wmem[off], d);
      chk(le_mode, "R7", "wide kept by non-zero offset", {31'd0, le_mode}, 1);
      wc = u_be_bus.wcount;
      do_req(1'b0, off, 16'h0000, lat);
      chk(lat == NS + 1, "R3", "wide read latency", lat, NS + 1);
      chk(le_rdata == d && be_rdata == d, "R3", "wide read word", le_rdata, d);
      chk(u_be_bus.wcount == wc, "R9", "no bus write during wide read", u_be_bus.wcount, wc);
    end

    // R7: back to narrow
    do_req(1'b1, 8'h00, 16'hFFFE, lat);
    chk(lat == NS + 1, "R7", "mode write at wide width", lat, NS + 1);
    chk(u_le_bus.wmem[0] == 16'hFFFE, "R7", "mode value on wide bus", u_le_bus.wmem[0], 16'hFFFE);
    chk(!le_mode && !be_mode, "R7", "narrow restored", {31'd0, le_mode}, 0);
    do_req(1'b0, 8'h40, 16'h0000, lat);
    chk(lat == 2*NS + 1 && le_rdata == 16'h1234, "R4", "narrow after return",
        le_rdata, 16'h1234);
    @(negedge clk);
    chk(le_ready && !le_done, "R2", "ready after done", {30'd0, le_ready, le_done}, 32'h2);

    summary();
  end
endmodule